// File: doc/BRIEF.md
# SPI Slave Port

A serial peripheral interface target that lives entirely in the system clock domain. The serial clock, the data input and the active-low select pass through a two-stage synchroniser. Clock edges are then classified as sampling or driving edges according to the programmed clock polarity and phase. A word of 8 to 16 bits is shifted in from the bus while a word taken from the transmit holding register is shifted out. The data output is enabled only while the port is selected.

Software sees four registers: control, status, data and interrupt. A completed word is copied to a single receive buffer and raises a completion flag. A word that completes while that flag is still set raises an overrun flag. A select release before the final bit has been sampled raises an abort flag and discards both words. The serial clock must run at no more than a quarter of the system clock. Between select falling and the first serial clock edge, the master must leave at least four system clock cycles.

Top module: `spi_sub_port`

## Requirements
- R1: `miso_oe_o` is 0 while select is deasserted and 1 while it is asserted, each after the synchroniser delay. `miso_o` is 0 whenever the enable is 0.
- R2: Control bits are: bit 2 width enable, bit 3 clock phase, bit 4 clock polarity, bit 6 LSB-first, bit 7 interrupt enable, bits 11:8 width code. With polarity 0 and phase 0, the first output bit (MSB-first by default) is on MISO before the first rising edge. Input is sampled on rising edges and output changes on falling edges.
- R3: With phase 1, each output bit changes on the first edge of its bit period and input is sampled on the second edge. Polarity 1 inverts the idle level and swaps the edge directions.
- R4: Word length is 8 when bit 2 is 0. When bit 2 is 1: code 0 gives 16, codes 8 to 15 give that many bits, and codes 1 to 7 give 8. The received word is right-aligned in the data register.
- R5: With bit 6 set, both directions move the least significant bit first.
- R6: Status bit 7 sets on the last sampling edge of a word. It clears on a data register read or write that follows a status read made while the bit was set.
- R7: Status bit 5 sets when a word completes while bit 7 is still set. In that case the receive buffer keeps its old word and the new word is dropped. Bit 5 clears on a status read.
- R8: A select rise after at least one sampled bit and before the last one sets status bit 3. The receive buffer and bit 7 stay unchanged, and the transmit holding register becomes 0. Bit 3 clears on a status read, but a set in the same cycle as that read wins.
- R9: The transmit shift register is loaded from the holding register on each select fall. Without a new write, the same word is sent again.
- R10: Interrupt register (address 3) bit 0 sets when control bit 7 is 1 and a word completes or aborts. Writing 1 to it clears it. `irq_o` shows it.
- R11: The master-select control bit (bit 5) and all unimplemented control bits always read 0.
- R12: Serial clock edges after a word has completed and before select rises change neither the buffer nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| ss_ni | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data, 3 interrupt |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The abort flag can be set by a select release in the same cycle that a status read clears it. If clearing took priority, the abort would vanish unseen. The bench provokes this by raising select mid-word and then holding a status read asserted on every cycle across the whole window where the flag can land. It then counts how many of those reads return bit 3 set: exactly one is correct, and zero means the collision lost the event.

// File: rtl/spi_sub_pkg.sv
`timescale 1ns/1ps
package spi_sub_pkg;
  localparam int DATA_W = 16;
  localparam int MIN_W  = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_INT  = 2'd3
  } reg_addr_e;

  localparam int CB_WEN  = 2;
  localparam int CB_CPHA = 3;
  localparam int CB_CPOL = 4;
  localparam int CB_MSTR = 5;
  localparam int CB_LSBF = 6;
  localparam int CB_IRQE = 7;
  localparam int CB_WLO  = 8;
  localparam int CB_WHI  = 11;

  localparam int SB_ABRT = 3;
  localparam int SB_OVR  = 5;
  localparam int SB_DONE = 7;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << CB_WEN) | (1 << CB_CPHA) | (1 << CB_CPOL) | (1 << CB_LSBF) |
            (1 << CB_IRQE) | (((1 << (CB_WHI - CB_WLO + 1)) - 1) << CB_WLO));

  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             lsbf;
    logic [CNT_W-1:0] wlen;
  } cfg_t;
endpackage

// File: rtl/spi_sub_sync.sv
`timescale 1ns/1ps
module spi_sub_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_sub_edge.sv
`timescale 1ns/1ps
module spi_sub_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic ss_s_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sample_o,
  output logic drive_o,
  output logic sel_fall_o,
  output logic sel_rise_o,
  output logic sel_act_o
);
  logic sck_q, ss_q;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      ss_q  <= ss_s_i;
    end
  end

  assign rise  = sck_s_i & ~sck_q;
  assign fall  = ~sck_s_i & sck_q;
  // leading edge leaves the idle level
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;

  assign sel_act_o  = ~ss_s_i;
  assign sel_fall_o = ss_q & ~ss_s_i;
  assign sel_rise_o = ~ss_q & ss_s_i;
  assign sample_o   = sel_act_o & (cpha_i ? trail : lead);
  assign drive_o    = sel_act_o & (cpha_i ? lead : trail);
endmodule

// File: rtl/spi_sub_shift.sv
`timescale 1ns/1ps
module spi_sub_shift #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              drive_i,
  input  logic              sel_fall_i,
  input  logic              sel_rise_i,
  input  logic              mosi_i,
  input  logic              cpha_i,
  input  logic              lsbf_i,
  input  logic [CNT_W-1:0]  wlen_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, rx_aligned, mask;
  logic [DATA_W:0]   one_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              started, fin, last_bit, drive_ok;

  assign rx_next    = lsbf_i ? {mosi_i, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], mosi_i};
  assign one_sh     = (DATA_W+1)'(1) << wlen_i;
  assign mask       = one_sh[DATA_W-1:0] - 1'b1;
  assign rx_aligned = lsbf_i ? (rx_next >> (CNT_W'(DATA_W) - wlen_i)) : (rx_next & mask);
  assign last_bit   = (bit_cnt == wlen_i - 1'b1);
  // phase 1: first leading edge presents bit 0 that is already loaded
  assign drive_ok   = ~cpha_i | (bit_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      bit_cnt   <= '0;
      started   <= 1'b0;
      fin       <= 1'b0;
      done_o    <= 1'b0;
      abort_o   <= 1'b0;
      rx_word_o <= '0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (sel_fall_i) begin
        tx_sh   <= tx_word_i;
        bit_cnt <= '0;
        started <= 1'b0;
        fin     <= 1'b0;
      end else if (sel_rise_i) begin
        if (started && !fin) abort_o <= 1'b1;
        bit_cnt <= '0;
        started <= 1'b0;
        fin     <= 1'b0;
      end else if (!fin) begin
        if (sample_i) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          started <= 1'b1;
          if (last_bit) begin
            fin       <= 1'b1;
            done_o    <= 1'b1;
            rx_word_o <= rx_aligned;
          end
        end
        if (drive_i && drive_ok) begin
          tx_sh <= lsbf_i ? (tx_sh >> 1) : (tx_sh << 1);
        end
      end
    end
  end

  assign miso_o = lsbf_i ? tx_sh[0] : tx_sh[wlen_i - 1'b1];

  AST_FIN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fin) && !$past(sel_fall_i) && !$past(sel_rise_i)) |-> $stable(rx_sh)); // R12
  AST_ABORT_PAIRS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(sel_rise_i)); // R8
  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sample_i)); // R6
endmodule

// File: rtl/spi_sub_regs.sv
`timescale 1ns/1ps
module spi_sub_regs
  import spi_sub_pkg::*;
#(
  parameter int DATA_W = spi_sub_pkg::DATA_W,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cpha_o,
  output logic              cpol_o,
  output logic              lsbf_o,
  output logic [CNT_W-1:0]  wlen_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              irq_o
);
  localparam int CODE_W = CB_WHI - CB_WLO + 1;

  logic [DATA_W-1:0] ctrl_q, rx_buf, tx_data;
  logic              done_f, ovr_f, abrt_f, arm_f, int_f;
  logic              stat_rd, data_acc, int_clr, take, ovr_set, done_clr;
  logic [CODE_W-1:0] code;
  reg_addr_e         addr;

  assign addr     = reg_addr_e'(addr_i);
  assign stat_rd  = rd_i & (addr == ADDR_STAT);
  assign data_acc = (rd_i | wr_i) & (addr == ADDR_DATA);
  assign int_clr  = wr_i & (addr == ADDR_INT) & wdata_i[0];
  assign take     = done_i & ~done_f;
  assign ovr_set  = done_i & done_f;
  assign done_clr = arm_f & data_acc;

  assign code = ctrl_q[CB_WHI:CB_WLO];
  always_comb begin
    if (!ctrl_q[CB_WEN])            wlen_o = CNT_W'(MIN_W);
    else if (code == '0)            wlen_o = CNT_W'(DATA_W);
    else if (int'(code) < MIN_W)    wlen_o = CNT_W'(MIN_W);
    else                            wlen_o = CNT_W'(code);
  end

  assign cpha_o    = ctrl_q[CB_CPHA];
  assign cpol_o    = ctrl_q[CB_CPOL];
  assign lsbf_o    = ctrl_q[CB_LSBF];
  assign tx_word_o = tx_data;
  assign irq_o     = int_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rx_buf  <= '0;
      tx_data <= '0;
      done_f  <= 1'b0;
      ovr_f   <= 1'b0;
      abrt_f  <= 1'b0;
      arm_f   <= 1'b0;
      int_f   <= 1'b0;
    end else begin
      if (wr_i && addr == ADDR_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_i && addr == ADDR_DATA) tx_data <= wdata_i;
      else if (abort_i)              tx_data <= '0;
      if (take) rx_buf <= rx_word_i;
      // set beats clear on every flag
      done_f <= take | (done_f & ~done_clr);
      arm_f  <= (stat_rd & done_f) | (arm_f & ~data_acc & done_f);
      ovr_f  <= ovr_set | (ovr_f & ~stat_rd);
      abrt_f <= abort_i | (abrt_f & ~stat_rd);
      int_f  <= (ctrl_q[CB_IRQE] & (done_i | abort_i)) | (int_f & ~int_clr);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: begin
        rdata_o[SB_DONE] = done_f;
        rdata_o[SB_OVR]  = ovr_f;
        rdata_o[SB_ABRT] = abrt_f;
      end
      ADDR_DATA: rdata_o = rx_buf;
      ADDR_INT:  rdata_o[0] = int_f;
    endcase
  end

  AST_ABORT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> abrt_f); // R8
  AST_OVR_KEEPS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_f) |=> ($stable(rx_buf) && ovr_f)); // R7
  AST_OVR_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !ovr_set) |=> !ovr_f); // R7
  AST_IRQ_FROM_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_f) |-> $past(done_i || abort_i)); // R10
  AST_MSTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr == ADDR_CTRL) |=> !ctrl_q[CB_MSTR]); // R11
endmodule

// File: rtl/spi_sub_port.sv
`timescale 1ns/1ps
module spi_sub_port
  import spi_sub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [2:0]        pins_s;
  logic              sample, drive, sel_fall, sel_rise, sel_act, miso_raw;
  logic              done, abort;
  logic [DATA_W-1:0] rx_word, tx_word;
  cfg_t              cfg;

  spi_sub_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_sub_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s[0]),
    .ss_s_i    (pins_s[2]),
    .cpol_i    (cfg.cpol),
    .cpha_i    (cfg.cpha),
    .sample_o  (sample),
    .drive_o   (drive),
    .sel_fall_o(sel_fall),
    .sel_rise_o(sel_rise),
    .sel_act_o (sel_act)
  );

  spi_sub_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample),
    .drive_i   (drive),
    .sel_fall_i(sel_fall),
    .sel_rise_i(sel_rise),
    .mosi_i    (pins_s[1]),
    .cpha_i    (cfg.cpha),
    .lsbf_i    (cfg.lsbf),
    .wlen_i    (cfg.wlen),
    .tx_word_i (tx_word),
    .miso_o    (miso_raw),
    .done_o    (done),
    .abort_o   (abort),
    .rx_word_o (rx_word)
  );

  spi_sub_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .done_i   (done),
    .abort_i  (abort),
    .rx_word_i(rx_word),
    .rdata_o  (reg_rdata_o),
    .cpha_o   (cfg.cpha),
    .cpol_o   (cfg.cpol),
    .lsbf_o   (cfg.lsbf),
    .wlen_o   (cfg.wlen),
    .tx_word_o(tx_word),
    .irq_o    (irq_o)
  );

  assign miso_oe_o = sel_act;
  assign miso_o    = sel_act & miso_raw;

  AST_OE_OFF_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ss_ni) && $past(ss_ni, 2) && $past(ss_ni, 3)) |-> (!miso_oe_o && !miso_o)); // R1
  AST_OE_ON_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ss_ni) && !$past(ss_ni, 2) && !$past(ss_ni, 3)) |-> miso_oe_o); // R1
endmodule

// File: tb/tb_spi_sub_port.sv
`timescale 1ns/1ps
module tb_spi_sub_port;
  localparam int H = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic        miso, miso_oe, irq;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  int          total = 0, bad = 0;
  logic        oe_mid;
  bit          finished = 0;

  always #5 clk = ~clk;

  spi_sub_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // master model; stops after 'stop' bits (abort when stop < nb), leaves select high on return
  task automatic xfer(input logic [15:0] mo, input int nb, input logic cp, input logic ph,
                      input logic lf, input int extra, input int stop, output logic [15:0] mi);
    mi = '0;
    sck = cp;
    cyc(4);
    ss_n = 1'b0;
    cyc(8);
    oe_mid = miso_oe;
    for (int i = 0; i < nb; i++) begin
      int idx;
      if (i == stop) break;
      idx = lf ? i : nb - 1 - i;
      if (!ph) begin
        mosi = mo[idx]; cyc(H); mi[idx] = miso; sck = ~cp; cyc(H); sck = cp;
      end else begin
        sck = ~cp; mosi = mo[idx]; cyc(H); mi[idx] = miso; sck = cp; cyc(H);
      end
    end
    for (int e = 0; e < extra; e++) begin
      cyc(H); sck = ~cp; mosi = ~mosi; cyc(H); sck = cp;
    end
    cyc(H);
    ss_n = 1'b1;
  endtask

  task automatic drain(input logic [15:0] exp_stat, input logic [15:0] exp_data, input string tag);
    logic [15:0] v;
    rreg(2'd1, v); chk({tag, " status"}, v, exp_stat);
    rreg(2'd2, v); chk({tag, " data"}, v, exp_data);
    rreg(2'd1, v); chk({tag, " status cleared R6"}, v, 16'h0000);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 oe at reset", {15'b0, miso_oe}, 16'h0);
    chk("R1 miso at reset", {15'b0, miso}, 16'h0);
    chk("R10 irq at reset", {15'b0, irq}, 16'h0);
    rreg(2'd1, v); chk("R6 status at reset", v, 16'h0);
    rreg(2'd0, v); chk("R11 ctrl at reset", v, 16'h0);
  endtask

  task automatic t_mode0_irq;
    logic [15:0] mi, v;
    wreg(2'd0, 16'h0080);
    wreg(2'd2, 16'h00A5);
    xfer(16'h003C, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R1 oe while selected", {15'b0, oe_mid}, 16'h1);
    chk("R1 oe after release", {15'b0, miso_oe}, 16'h0);
    chk("R2 mode0 miso word", mi, 16'h00A5);
    chk("R10 irq raised", {15'b0, irq}, 16'h1);
    rreg(2'd3, v); chk("R10 int reg", v, 16'h1);
    wreg(2'd3, 16'h0001);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);
    drain(16'h0080, 16'h003C, "R2 R6 mode0");
  endtask

  task automatic t_resend;
    logic [15:0] mi;
    xfer(16'h0011, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R9 resend last word", mi, 16'h00A5);
    drain(16'h0080, 16'h0011, "R9");
    wreg(2'd3, 16'h0001);
  endtask

  task automatic t_mode3_w16;
    logic [15:0] mi;
    wreg(2'd0, 16'h001C);
    wreg(2'd2, 16'hBEEF);
    xfer(16'h1234, 16, 1'b1, 1'b1, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R3 R4 mode3 16b miso", mi, 16'hBEEF);
    drain(16'h0080, 16'h1234, "R3 R4 mode3");
  endtask

  task automatic t_mode1_lsb12;
    logic [15:0] mi;
    wreg(2'd0, 16'h0C4C);
    wreg(2'd2, 16'h05A3);
    xfer(16'h09C1, 12, 1'b0, 1'b1, 1'b1, 0, 99, mi);
    cyc(8);
    chk("R5 R3 lsb-first 12b miso", mi, 16'h05A3);
    drain(16'h0080, 16'h09C1, "R5 R4 lsb12");
  endtask

  task automatic t_mode2_w10;
    logic [15:0] mi;
    wreg(2'd0, 16'h0A14);
    wreg(2'd2, 16'h02B7);
    xfer(16'h0155, 10, 1'b1, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R3 R4 mode2 10b miso", mi, 16'h02B7);
    drain(16'h0080, 16'h0155, "R4 mode2");
  endtask

  task automatic t_small_code;
    logic [15:0] mi;
    wreg(2'd0, 16'h0304);
    wreg(2'd2, 16'h005E);
    xfer(16'h00C3, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R4 code 3 means 8 bits", mi, 16'h005E);
    drain(16'h0080, 16'h00C3, "R4 code3");
  endtask

  task automatic t_overrun;
    logic [15:0] mi, v;
    wreg(2'd0, 16'h0000);
    xfer(16'h0011, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    xfer(16'h0022, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    rreg(2'd1, v); chk("R7 overrun status", v, 16'h00A0);
    rreg(2'd2, v); chk("R7 old word kept", v, 16'h0011);
    rreg(2'd1, v); chk("R7 overrun cleared", v, 16'h0000);
  endtask

  task automatic t_abort;
    logic [15:0] mi, v;
    int seen_ab, seen_done;
    wreg(2'd2, 16'h0077);
    xfer(16'h00F0, 8, 1'b0, 1'b0, 1'b0, 0, 3, mi);
    seen_ab = 0; seen_done = 0;
    // status read held every cycle across the window where the abort lands
    addr = 2'd1; rd = 1'b1;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (rdata[3]) seen_ab++;
      if (rdata[7]) seen_done++;
      @(negedge clk);
    end
    rd = 1'b0;
    chk("R8 abort seen once under read collision", 16'(seen_ab), 16'd1);
    chk("R8 no completion on abort", 16'(seen_done), 16'd0);
    rreg(2'd2, v); chk("R8 receive buffer untouched", v, 16'h0011);
    xfer(16'h0033, 8, 1'b0, 1'b0, 1'b0, 0, 99, mi);
    cyc(8);
    chk("R8 transmit word discarded", mi, 16'h0000);
    drain(16'h0080, 16'h0033, "R8 after abort");
  endtask

  task automatic t_extra_edges;
    logic [15:0] mi;
    wreg(2'd2, 16'h0081);
    xfer(16'h0069, 8, 1'b0, 1'b0, 1'b0, 3, 99, mi);
    cyc(8);
    chk("R12 word before extra edges", mi, 16'h0081);
    drain(16'h0080, 16'h0069, "R12 extra edges");
  endtask

  task automatic t_ctrl_bits;
    logic [15:0] v;
    wreg(2'd0, 16'h0020);
    rreg(2'd0, v); chk("R11 master bit reads 0", v, 16'h0000);
    wreg(2'd0, 16'hFFFF);
    rreg(2'd0, v); chk("R11 implemented bits only", v, 16'h0FDC);
    wreg(2'd0, 16'h0000);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_mode0_irq();
    t_resend();
    t_mode3_w16();
    t_mode1_lsb12();
    t_mode2_w10();
    t_small_code();
    t_overrun();
    t_abort();
    t_extra_edges();
    t_ctrl_bits();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule